// File: doc/BRIEF.md
# Six-Step Address Unlock Detector

This block watches the stream of completed, chip-enable-qualified accesses on a memory's address bus and recognises two fixed six-read address signatures. Both signatures begin with the same five-address prefix: 0E38, 31C7, 03E0, 3C1F, 303F (hex). They differ only in the sixth read. A sixth read at 0FC0 requests a nonvolatile save. A sixth read at 0C63 requests a recall. A recognised signature produces a one-cycle pulse on the matching request output. The engine that performs the save or recall acts on that pulse.

Every access is reported by one `acc_strobe` cycle. On that cycle the bus carries the address and the write-enable level. A write, or a read of any address that is not the next expected one, aborts the sequence. A busy input forces the detector back to idle and hides accesses while the save or recall engine works.

A save request does not depend on whether the array has been written since the last nonvolatile cycle. For that reason the block has no written-since-last-save input.

Top module: `nv_unlock_detect`

## Requirements
- R1: After reset, `store_req`, `recall_req` and `rd_pass` are low and the detector is idle. A lone read at 0FC0 or 0C63 then produces no request.
- R2: The five prefix reads followed by a read at 0FC0 make `store_req` high for exactly one cycle. That cycle is the one after the sixth strobe.
- R3: The five prefix reads followed by a read at 0C63 make `recall_req` high for exactly one cycle. That cycle is the one after the sixth strobe.
- R4: Only address bits 13:0 are compared. The level of bit 14 on any step does not change recognition.
- R5: A strobe with `acc_we_n` low (a write) at any step aborts the sequence. The rest of the signature then gives no request.
- R6: A read at an address other than the next expected one aborts the sequence. This includes a wrong sixth address. No request follows.
- R7: The level of `acc_oe_n` has no effect on recognition or on the outputs.
- R8: A read at 0E38 that aborts a partly matched sequence counts as step one of a new sequence.
- R9: While `busy` is high, strobes are ignored and produce no output pulse, and the detector returns to idle.
- R10: An accepted read that is not a recognised sixth step gives a one-cycle `rd_pass` pulse in the following cycle. A recognised sixth read gives a request instead of `rd_pass`. Writes give no `rd_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_strobe | input | 1 | One cycle per completed enabled access |
| acc_addr | input | ADDR_W (15) | Address of the access |
| acc_we_n | input | 1 | Write-enable level, low means write |
| acc_oe_n | input | 1 | Output-enable level, does not affect detection |
| busy | input | 1 | Save/recall engine busy, freezes detection |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle recall request |
| rd_pass | output | 1 | Access completed as an ordinary read |

## Verification
The bench builds the block with its default parameters: a 15-bit address bus, 14 compared bits, six steps, and restart-on-first-key enabled. The 15-bit bus lets the bench set bit 14 on every step of a signature and show that recognition is unchanged. The enabled restart variant makes it possible to test an aborting 0E38 read that leads into a complete recall.

// File: rtl/nv_unlock_pkg.sv
package nv_unlock_pkg;
   localparam int unsigned KEY_W      = 14;
   localparam int unsigned PREFIX_LEN = 5;
   typedef logic [KEY_W-1:0] key_t;
   // Shared prefix, in the order it must be read
   localparam key_t PREFIX_KEYS [PREFIX_LEN] =
      '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
   localparam key_t STORE_KEY  = 14'h0FC0;
   localparam key_t RECALL_KEY = 14'h0C63;
endpackage

// File: rtl/nv_unlock_match.sv
module nv_unlock_match #(
   parameter int unsigned STEPS = 6,
   localparam int unsigned PREFIX = STEPS - 1,
   localparam int unsigned SW = $clog2(STEPS)
) (
   input  logic [nv_unlock_pkg::KEY_W-1:0] addr_lo,
   input  logic [SW-1:0]                   step,
   output logic                            hit_expected,
   output logic                            hit_first,
   output logic                            hit_store,
   output logic                            hit_recall
);
   import nv_unlock_pkg::*;

   logic [PREFIX-1:0] eq;

   for (genvar i = 0; i < PREFIX; i++) begin : g_cmp
      assign eq[i] = (addr_lo == PREFIX_KEYS[i]);
   end

   always_comb begin
      hit_expected = 1'b0;
      for (int i = 0; i < PREFIX; i++) begin
         if (step == SW'(i)) hit_expected = eq[i];
      end
   end

   assign hit_first  = eq[0];
   assign hit_store  = (addr_lo == STORE_KEY);
   assign hit_recall = (addr_lo == RECALL_KEY);
endmodule

// File: rtl/nv_unlock_fsm.sv
module nv_unlock_fsm #(
   parameter int unsigned STEPS = 6,
   parameter bit RESTART_ON_FIRST = 1'b1,
   localparam int unsigned PREFIX = STEPS - 1,
   localparam int unsigned SW = $clog2(STEPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_strobe,
   input  logic          acc_we_n,
   input  logic          busy,
   input  logic          hit_expected,
   input  logic          hit_first,
   input  logic          hit_store,
   input  logic          hit_recall,
   output logic [SW-1:0] step,
   output logic          store_req,
   output logic          recall_req,
   output logic          rd_pass
);
   logic          rd_ok, at_last, fire_store, fire_recall;
   logic [SW-1:0] restart_step, step_nxt;

   assign rd_ok       = acc_strobe & acc_we_n & ~busy;
   assign at_last     = (step == SW'(PREFIX));
   assign fire_store  = rd_ok & at_last & hit_store;
   assign fire_recall = rd_ok & at_last & hit_recall;

   if (RESTART_ON_FIRST) begin : g_restart
      assign restart_step = hit_first ? SW'(1) : '0;
   end else begin : g_plain
      assign restart_step = '0;
   end

   always_comb begin
      step_nxt = step;
      if (busy) begin
         step_nxt = '0;
      end else if (acc_strobe) begin
         if (!acc_we_n)                            step_nxt = '0;
         else if (!at_last && hit_expected)        step_nxt = step + SW'(1);
         else if (at_last && (hit_store || hit_recall)) step_nxt = '0;
         else                                      step_nxt = restart_step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step       <= '0;
         store_req  <= 1'b0;
         recall_req <= 1'b0;
         rd_pass    <= 1'b0;
      end else begin
         step       <= step_nxt;
         store_req  <= fire_store;
         recall_req <= fire_recall;
         rd_pass    <= rd_ok & ~fire_store & ~fire_recall;
      end
   end

   AST_STORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);                                     // R2
   AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> !recall_req);                                   // R3
   AST_REQ_AFTER_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> $past(step) == SW'(PREFIX));     // R2
   AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_strobe && !acc_we_n) |=> (step == '0 && !store_req && !recall_req && !rd_pass)); // R5
   AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (step == '0 && !store_req && !recall_req && !rd_pass)); // R9
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_req, recall_req, rd_pass}));                   // R10
endmodule

// File: rtl/nv_unlock_detect.sv
module nv_unlock_detect #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned CMP_W = 14,
   parameter int unsigned STEPS = 6,
   parameter bit RESTART_ON_FIRST = 1'b1,
   localparam int unsigned SW = $clog2(STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_strobe,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_we_n,
   input  logic              acc_oe_n,
   input  logic              busy,
   output logic              store_req,
   output logic              recall_req,
   output logic              rd_pass
);
   if (CMP_W != nv_unlock_pkg::KEY_W) begin : g_bad_cmp
      $error("CMP_W must equal the key width");
   end
   if (ADDR_W < CMP_W) begin : g_bad_addr
      $error("ADDR_W must be at least CMP_W");
   end
   if (STEPS != nv_unlock_pkg::PREFIX_LEN + 1) begin : g_bad_steps
      $error("STEPS must be prefix length plus one");
   end

   logic [SW-1:0] step;
   logic hit_expected, hit_first, hit_store, hit_recall;

   // The output-enable level does not take part in detection (R7)
   logic unused_oe;
   assign unused_oe = acc_oe_n;

   // Address bits above the compared field are dropped (R4)
   if (ADDR_W > CMP_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^acc_addr[ADDR_W-1:CMP_W];
   end

   nv_unlock_match #(.STEPS(STEPS)) u_match (
      .addr_lo      (acc_addr[CMP_W-1:0]),
      .step         (step),
      .hit_expected (hit_expected),
      .hit_first    (hit_first),
      .hit_store    (hit_store),
      .hit_recall   (hit_recall)
   );

   nv_unlock_fsm #(.STEPS(STEPS), .RESTART_ON_FIRST(RESTART_ON_FIRST)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_strobe   (acc_strobe),
      .acc_we_n     (acc_we_n),
      .busy         (busy),
      .hit_expected (hit_expected),
      .hit_first    (hit_first),
      .hit_store    (hit_store),
      .hit_recall   (hit_recall),
      .step         (step),
      .store_req    (store_req),
      .recall_req   (recall_req),
      .rd_pass      (rd_pass)
   );
endmodule

// File: tb/nv_unlock_detect_tb_top.sv
module nv_unlock_detect_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_strobe = 1'b0;
   logic [14:0] acc_addr = '0;
   logic acc_we_n = 1'b1;
   logic acc_oe_n = 1'b0;
   logic busy = 1'b0;
   logic store_req, recall_req, rd_pass;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nv_unlock_detect dut_i (
      .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_addr(acc_addr),
      .acc_we_n(acc_we_n), .acc_oe_n(acc_oe_n), .busy(busy),
      .store_req(store_req), .recall_req(recall_req), .rd_pass(rd_pass)
   );

   task automatic chk(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   // One strobed access; outputs are sampled one cycle later
   task automatic acc(input logic [14:0] a, input logic we_n, input logic oe_n,
                      input logic exp_st, input logic exp_rc, input logic exp_ps,
                      input string req);
      @(negedge clk);
      acc_strobe = 1'b1; acc_addr = a; acc_we_n = we_n; acc_oe_n = oe_n;
      @(negedge clk);
      acc_strobe = 1'b0; acc_we_n = 1'b1; acc_oe_n = 1'b0;
      chk(store_req,  exp_st, {req, " store_req"});
      chk(recall_req, exp_rc, {req, " recall_req"});
      chk(rd_pass,    exp_ps, {req, " rd_pass"});
   endtask

   task automatic rd(input logic [14:0] a, input logic st, input logic rc, input string req);
      acc(a, 1'b1, 1'b0, st, rc, ~(st | rc), req);
   endtask

   task automatic prefix(input logic [14:0] hi, input string req);
      rd(15'h0E38 | hi, 0, 0, req);
      rd(15'h31C7 | hi, 0, 0, req);
      rd(15'h03E0 | hi, 0, 0, req);
      rd(15'h3C1F | hi, 0, 0, req);
      rd(15'h303F | hi, 0, 0, req);
   endtask

   task automatic t_reset();
      chk(store_req, 1'b0, "R1 reset store_req");
      chk(recall_req, 1'b0, "R1 reset recall_req");
      chk(rd_pass, 1'b0, "R1 reset rd_pass");
      rd(15'h0FC0, 0, 0, "R1 lone store key");
      rd(15'h0C63, 0, 0, "R1 lone recall key");
   endtask

   task automatic t_store();
      prefix(15'h0, "R10 prefix passes");
      rd(15'h0FC0, 1, 0, "R2 store sixth");
      @(negedge clk);
      chk(store_req, 1'b0, "R2 pulse one cycle");
   endtask

   task automatic t_recall();
      prefix(15'h0, "R10 prefix passes");
      rd(15'h0C63, 0, 1, "R3 recall sixth");
      @(negedge clk);
      chk(recall_req, 1'b0, "R3 pulse one cycle");
   endtask

   task automatic t_oe();
      acc(15'h0E38, 1, 1, 0, 0, 1, "R7 oe high");
      acc(15'h31C7, 1, 1, 0, 0, 1, "R7 oe high");
      acc(15'h03E0, 1, 0, 0, 0, 1, "R7 oe low");
      acc(15'h3C1F, 1, 1, 0, 0, 1, "R7 oe high");
      acc(15'h303F, 1, 1, 0, 0, 1, "R7 oe high");
      acc(15'h0FC0, 1, 1, 1, 0, 0, "R7 store with oe high");
   endtask

   task automatic t_hibit();
      prefix(15'h4000, "R4 bit14 set");
      rd(15'h4C63, 0, 1, "R4 recall with bit14 set");
   endtask

   task automatic t_write();
      rd(15'h0E38, 0, 0, "R5 lead");
      rd(15'h31C7, 0, 0, "R5 lead");
      acc(15'h03E0, 1'b0, 1'b1, 0, 0, 0, "R5 write aborts");
      rd(15'h3C1F, 0, 0, "R5 after abort");
      rd(15'h303F, 0, 0, "R5 after abort");
      rd(15'h0FC0, 0, 0, "R5 no store after write");
   endtask

   task automatic t_mismatch();
      rd(15'h0E38, 0, 0, "R6 lead");
      rd(15'h31C7, 0, 0, "R6 lead");
      rd(15'h1234, 0, 0, "R6 foreign read");
      rd(15'h03E0, 0, 0, "R6 after abort");
      rd(15'h3C1F, 0, 0, "R6 after abort");
      rd(15'h303F, 0, 0, "R6 after abort");
      rd(15'h0C63, 0, 0, "R6 no recall");
      prefix(15'h0, "R6 prefix");
      rd(15'h0FC1, 0, 0, "R6 wrong sixth");
      rd(15'h0FC0, 0, 0, "R6 late store key ignored");
   endtask

   task automatic t_restart();
      rd(15'h0E38, 0, 0, "R8 lead");
      rd(15'h31C7, 0, 0, "R8 lead");
      rd(15'h03E0, 0, 0, "R8 lead");
      rd(15'h0E38, 0, 0, "R8 abort on first key");
      rd(15'h31C7, 0, 0, "R8 continue");
      rd(15'h03E0, 0, 0, "R8 continue");
      rd(15'h3C1F, 0, 0, "R8 continue");
      rd(15'h303F, 0, 0, "R8 continue");
      rd(15'h0C63, 0, 1, "R8 recall after restart");
   endtask

   task automatic t_busy();
      rd(15'h0E38, 0, 0, "R9 lead");
      rd(15'h31C7, 0, 0, "R9 lead");
      @(negedge clk); busy = 1'b1;
      acc(15'h03E0, 1, 0, 0, 0, 0, "R9 strobe ignored while busy");
      @(negedge clk); busy = 1'b0;
      rd(15'h03E0, 0, 0, "R9 after busy");
      rd(15'h3C1F, 0, 0, "R9 after busy");
      rd(15'h303F, 0, 0, "R9 after busy");
      rd(15'h0FC0, 0, 0, "R9 progress cleared");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_store();
      t_recall();
      t_oe();
      t_hibit();
      t_write();
      t_mismatch();
      t_restart();
      t_busy();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule